// File: doc/BRIEF.md
# Bitplane Pass Sequencer with Rate and Quality Control

This block schedules the coding of one 64-coefficient unit of 8-bit magnitudes for a downstream bitplane coder. After a start pulse it walks the bitplanes from the top plane down. Inside each plane it runs three passes in a fixed order: insignificant coefficients, insignificant sets, then refinement of coefficients that are already significant. Each pass takes four slots of sixteen coefficients, one slot per clock. For every issued slot it presents the plane index, the pass identifier and the slot index. The coder answers in the same cycle with the number of bits it emitted for that slot.

The block also decides when coding ends. Lossless mode codes every plane and does not look at the emitted counts. Quality mode drops a chosen number of the lowest planes, from 0 to 7. The two fixed-ratio modes add up the emitted counts and stop once the total reaches half or a quarter of the raw unit size. A single-cycle done pulse follows the last issued slot. Mode and truncation count are captured when the start pulse is accepted.

Top module: `bitplane_pass_seq`

## Requirements
- R1: After reset, slotValid and done are 0 and planeIdx, passId and slotIdx are all 0.
- R2: A start pulse sampled while the block is idle causes the first slot in the next cycle, with planeIdx 7, passId 2'b00 and slotIdx 0.
- R3: Within a plane the passes run in the order 2'b00 (insignificant coefficients), 2'b01 (insignificant sets), 2'b10 (refinement). Each pass issues slotIdx 0,1,2,3 on consecutive cycles with no gap, and passId 2'b11 never appears.
- R4: Planes descend by one, from 7 toward the stop plane. A plane's first slot follows the previous plane's last slot with no gap.
- R5: In lossless mode (mode 2'b00) all 8 planes are coded (96 slots, last plane 0). bitsEmitted and truncCount have no effect.
- R6: In quality mode (mode 2'b01) with truncCount T (0..7), the last plane coded is T, giving (8-T)*12 slots.
- R7: In fixed-ratio mode the bitsEmitted values of the issued slots are summed, with a budget of 256 bits for mode 2'b10 and 128 bits for mode 2'b11. The slot that brings the total to the budget or beyond is the last one issued. bitsEmitted in cycles without a slot is not counted.
- R8: In fixed-ratio mode, when the budget is never reached, all 8 planes are coded.
- R9: done is high for exactly one cycle, in the cycle right after the last slot, and never together with slotValid.
- R10: Changes to startPulse, mode or truncCount while a unit is being coded do not change the slot sequence or its end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startPulse | input | 1 | Begin coding one unit (accepted when idle) |
| mode | input | 2 | 00 lossless, 01 quality, 10 ratio 2, 11 ratio 4 |
| truncCount | input | 3 | Number of low planes dropped in quality mode |
| bitsEmitted | input | 8 | Bits the coder emitted for the current slot |
| slotValid | output | 1 | A slot is issued this cycle |
| planeIdx | output | 3 | Bitplane of the current slot |
| passId | output | 2 | Pass of the current slot |
| slotIdx | output | 2 | Sixteen-coefficient group within the pass |
| done | output | 1 | One-cycle pulse after the last slot |

## Verification
Lossless runs use very large emitted counts and a nonzero truncation count. A run that ends early would show that either input leaked into lossless termination. Quality runs with truncation 0, 3 and 7 check the computed last plane at both ends of the range and once in between. Ratio runs with a constant 16 bits per slot reach the half budget exactly on slot 16, which tells apart a "greater or equal" stop from a "greater than" stop. A constant 50 overshoots the quarter budget on slot 3, and an irregular pattern stops part-way through a plane. Runs with zero or small counts never reach the budget and must code all planes. In some runs a start pulse, a different mode and a different truncation count are applied part-way through, and the slot sequence must not change.

// File: rtl/bitplane_pass_seq_pkg.sv
package bitplane_pass_seq_pkg;

  localparam logic [1:0] MODE_LOSSLESS = 2'b00;
  localparam logic [1:0] MODE_QUALITY  = 2'b01;
  localparam logic [1:0] MODE_HALF     = 2'b10;
  localparam logic [1:0] MODE_QUARTER  = 2'b11;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_FIN  = 2'b10
  } seqState_t;

  typedef struct packed {
    logic load;
    logic step;
  } seqStrobe_t;

endpackage

// File: rtl/bitplane_pass_seq_dp.sv
module bitplane_pass_seq_dp
  import bitplane_pass_seq_pkg::*;
#(
  parameter int PLANES = 8,
  parameter int PASSES = 3,
  parameter int SLOTS  = 4,
  parameter int LANES  = 16,
  parameter int CNT_W  = 8,
  localparam int PLANE_W = $clog2(PLANES),
  localparam int PASS_W  = $clog2(PASSES),
  localparam int SLOT_W  = $clog2(SLOTS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strobe,
  input  logic [1:0]         mode,
  input  logic [PLANE_W-1:0] truncCount,
  input  logic [CNT_W-1:0]   bitsEmitted,
  output logic [PLANE_W-1:0] planeIdx,
  output logic [PASS_W-1:0]  passId,
  output logic [SLOT_W-1:0]  slotIdx,
  output logic               lastSlot,
  output logic               budgetHit
);

  localparam int RAW_BITS    = LANES * SLOTS * PLANES;
  localparam int TOTAL_SLOTS = PLANES * PASSES * SLOTS;
  localparam int ACC_W       = CNT_W + $clog2(TOTAL_SLOTS) + 1;
  localparam logic [ACC_W:0] BUDGET_HALF    = (ACC_W+1)'(RAW_BITS / 2);
  localparam logic [ACC_W:0] BUDGET_QUARTER = (ACC_W+1)'(RAW_BITS / 4);
  localparam logic [PLANE_W-1:0] TOP_PLANE  = PLANE_W'(PLANES - 1);
  localparam logic [PASS_W-1:0]  LAST_PASS  = PASS_W'(PASSES - 1);
  localparam logic [SLOT_W-1:0]  LAST_SLOT  = SLOT_W'(SLOTS - 1);

  logic [PLANE_W-1:0] planeQ, stopPlaneQ;
  logic [PASS_W-1:0]  passQ;
  logic [SLOT_W-1:0]  slotQ;
  logic [ACC_W-1:0]   accQ;
  logic               ratioQ;
  logic [ACC_W:0]     budgetQ;
  logic [ACC_W:0]     accNext;
  logic               passEnd, planeEnd;

  assign passEnd  = (slotQ == LAST_SLOT);
  assign planeEnd = passEnd && (passQ == LAST_PASS);
  assign accNext  = {1'b0, accQ} + {{(ACC_W+1-CNT_W){1'b0}}, bitsEmitted};

  // Capture the job configuration and walk plane, pass and slot counters.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      planeQ     <= '0;
      passQ      <= '0;
      slotQ      <= '0;
      accQ       <= '0;
      stopPlaneQ <= '0;
      ratioQ     <= 1'b0;
      budgetQ    <= '0;
    end else if (strobe.load) begin
      planeQ     <= TOP_PLANE;
      passQ      <= '0;
      slotQ      <= '0;
      accQ       <= '0;
      stopPlaneQ <= (mode == MODE_QUALITY) ? truncCount : '0;
      ratioQ     <= mode[1];
      budgetQ    <= (mode == MODE_QUARTER) ? BUDGET_QUARTER : BUDGET_HALF;
    end else if (strobe.step) begin
      accQ <= accNext[ACC_W-1:0];
      if (passEnd) begin
        slotQ <= '0;
        if (planeEnd) begin
          passQ  <= '0;
          planeQ <= planeQ - 1'b1;
        end else begin
          passQ <= passQ + 1'b1;
        end
      end else begin
        slotQ <= slotQ + 1'b1;
      end
    end
  end

  assign lastSlot  = planeEnd && (planeQ == stopPlaneQ);
  assign budgetHit = ratioQ && (accNext >= budgetQ);

  assign planeIdx = planeQ;
  assign passId   = passQ;
  assign slotIdx  = slotQ;

endmodule

// File: rtl/bitplane_pass_seq_ctrl.sv
module bitplane_pass_seq_ctrl
  import bitplane_pass_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       lastSlot,
  input  logic       budgetHit,
  output seqStrobe_t strobe,
  output logic       slotValid,
  output logic       done
);

  seqState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: if (startPulse) stateD = ST_RUN;
      ST_RUN:  if (lastSlot || budgetHit) stateD = ST_FIN;
      ST_FIN:  stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign strobe.load = (stateQ == ST_IDLE) && startPulse;
  assign strobe.step = (stateQ == ST_RUN);
  assign slotValid   = (stateQ == ST_RUN);
  assign done        = (stateQ == ST_FIN);

endmodule

// File: rtl/bitplane_pass_seq.sv
module bitplane_pass_seq
  import bitplane_pass_seq_pkg::*;
#(
  parameter int PLANES = 8,
  parameter int PASSES = 3,
  parameter int SLOTS  = 4,
  parameter int LANES  = 16,
  parameter int CNT_W  = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       startPulse,
  input  logic [1:0]                 mode,
  input  logic [$clog2(PLANES)-1:0]  truncCount,
  input  logic [CNT_W-1:0]           bitsEmitted,
  output logic                       slotValid,
  output logic [$clog2(PLANES)-1:0]  planeIdx,
  output logic [$clog2(PASSES)-1:0]  passId,
  output logic [$clog2(SLOTS)-1:0]   slotIdx,
  output logic                       done
);

  seqStrobe_t strobe;
  logic       lastSlot;
  logic       budgetHit;

  bitplane_pass_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .lastSlot   (lastSlot),
    .budgetHit  (budgetHit),
    .strobe     (strobe),
    .slotValid  (slotValid),
    .done       (done)
  );

  bitplane_pass_seq_dp #(
    .PLANES (PLANES),
    .PASSES (PASSES),
    .SLOTS  (SLOTS),
    .LANES  (LANES),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .mode        (mode),
    .truncCount  (truncCount),
    .bitsEmitted (bitsEmitted),
    .planeIdx    (planeIdx),
    .passId      (passId),
    .slotIdx     (slotIdx),
    .lastSlot    (lastSlot),
    .budgetHit   (budgetHit)
  );

endmodule

// File: rtl/bitplane_pass_seq_chk.sv
module bitplane_pass_seq_chk #(
  parameter int PLANES = 8,
  parameter int PASSES = 3,
  parameter int SLOTS  = 4,
  localparam int PLANE_W = $clog2(PLANES),
  localparam int PASS_W  = $clog2(PASSES),
  localparam int SLOT_W  = $clog2(SLOTS)
) (
  input logic               clk,
  input logic               rstN,
  input logic               slotValid,
  input logic               done,
  input logic [PLANE_W-1:0] planeIdx,
  input logic [PASS_W-1:0]  passId,
  input logic [SLOT_W-1:0]  slotIdx
);

  assert_first_slot_R2: assert property (@(posedge clk) disable iff (!rstN)
    (slotValid && !$past(slotValid)) |->
      (planeIdx == PLANE_W'(PLANES - 1)) && (passId == '0) && (slotIdx == '0));

  assert_pass_legal_R3: assert property (@(posedge clk) disable iff (!rstN)
    slotValid |-> (passId < PASS_W'(PASSES)));

  assert_slot_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (slotValid && slotIdx != '0) |->
      $past(slotValid) && (slotIdx == SLOT_W'($past(slotIdx) + 1'b1)) &&
      (passId == $past(passId)));

  assert_pass_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (slotValid && slotIdx == '0 && passId != '0) |->
      $past(slotValid) && (passId == PASS_W'($past(passId) + 1'b1)) &&
      (planeIdx == $past(planeIdx)));

  assert_plane_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (slotValid && $past(slotValid) && slotIdx == '0 && passId == '0) |->
      (planeIdx == PLANE_W'($past(planeIdx) - 1'b1)));

  assert_done_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !slotValid && $past(slotValid));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

bind bitplane_pass_seq bitplane_pass_seq_chk #(
  .PLANES (PLANES),
  .PASSES (PASSES),
  .SLOTS  (SLOTS)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .slotValid (slotValid),
  .done      (done),
  .planeIdx  (planeIdx),
  .passId    (passId),
  .slotIdx   (slotIdx)
);

// File: tb/bitplane_pass_seq_test.sv
module bitplane_pass_seq_test;

  typedef struct packed {
    logic [2:0] plane;
    logic [1:0] pass;
    logic [1:0] slot;
    logic       fin;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startPulse = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [2:0] truncCount = 3'd0;
  logic [7:0] bitsEmitted = 8'd0;
  logic       slotValid, done;
  logic [2:0] planeIdx;
  logic [1:0] passId, slotIdx;

  int checks = 0;
  int errors = 0;
  int slotNo = 0;
  int patSel = 0;
  int constBits = 0;
  string reqTag = "R1";
  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  bitplane_pass_seq uut (
    .clk (clk), .rstN (rstN), .startPulse (startPulse), .mode (mode),
    .truncCount (truncCount), .bitsEmitted (bitsEmitted), .slotValid (slotValid),
    .planeIdx (planeIdx), .passId (passId), .slotIdx (slotIdx), .done (done)
  );

  function automatic int bitsFor(int k);
    if (patSel == 0) return constBits;
    return ((k * 7) % 23) + 1;
  endfunction

  task automatic check(string tag, bit ok, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // Driver: compute expected slot list from the requirements, then start the job.
  task automatic runJob(string tag, logic [1:0] m, logic [2:0] t, int sel, int cb, bit perturb);
    int acc = 0;
    int k = 0;
    int budget;
    int stopPlane;
    bit stop = 0;
    expItem_t it;
    reqTag = tag;
    patSel = sel;
    constBits = cb;
    budget = (m == 2'b11) ? 128 : 256;
    stopPlane = (m == 2'b01) ? int'(t) : 0;
    for (int p = 7; p >= stopPlane && !stop; p--)
      for (int ps = 0; ps < 3 && !stop; ps++)
        for (int s = 0; s < 4 && !stop; s++) begin
          k++;
          acc += bitsFor(k);
          it = '{plane: 3'(p), pass: 2'(ps), slot: 2'(s), fin: 1'b0};
          expQ.push_back(it);
          if (m[1] && acc >= budget) stop = 1;
        end
    it = '{plane: 3'd0, pass: 2'd0, slot: 2'd0, fin: 1'b1};
    expQ.push_back(it);
    @(negedge clk);
    slotNo = 0;
    mode = m;
    truncCount = t;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    if (perturb) begin
      repeat (5) @(negedge clk);
      startPulse = 1'b1;
      mode = ~m;
      truncCount = 3'd5;
      @(negedge clk);
      startPulse = 1'b0;
      mode = 2'b11;
    end
    while (expQ.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Monitor: compare each issued slot and done pulse against the queue.
  initial begin
    expItem_t e;
    forever begin
      @(negedge clk);
      if (slotValid || done) begin
        if (expQ.size() == 0) begin
          check({reqTag, " R9 unexpected output"}, 1'b0, 1, 0);
        end else begin
          e = expQ.pop_front();
          if (e.fin) begin
            check({reqTag, " R9 done"}, done && !slotValid, int'(done), 1);
          end else begin
            check({reqTag, " R3 slot"}, slotValid && !done &&
                  planeIdx == e.plane && passId == e.pass && slotIdx == e.slot,
                  {int'(planeIdx), int'(passId), int'(slotIdx)} == 0 ? 0 :
                  int'(planeIdx) * 100 + int'(passId) * 10 + int'(slotIdx),
                  int'(e.plane) * 100 + int'(e.pass) * 10 + int'(e.slot));
          end
        end
      end
      if (slotValid) begin
        slotNo++;
        bitsEmitted = 8'(bitsFor(slotNo));
      end else begin
        bitsEmitted = 8'd255;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 slotValid", slotValid == 1'b0, int'(slotValid), 0);
    check("R1 done", done == 1'b0, int'(done), 0);
    check("R1 indices", planeIdx == 0 && passId == 0 && slotIdx == 0,
          int'(planeIdx) * 100 + int'(passId) * 10 + int'(slotIdx), 0);

    runJob("R5 lossless big counts", 2'b00, 3'd5, 0, 200, 1'b1);
    runJob("R2 R10 lossless", 2'b00, 3'd0, 1, 0, 1'b1);
    runJob("R6 quality T0", 2'b01, 3'd0, 0, 255, 1'b0);
    runJob("R6 R10 quality T3", 2'b01, 3'd3, 0, 255, 1'b1);
    runJob("R6 quality T7", 2'b01, 3'd7, 0, 255, 1'b0);
    runJob("R7 half exact", 2'b10, 3'd0, 0, 16, 1'b1);
    runJob("R7 quarter overshoot", 2'b11, 3'd0, 0, 50, 1'b0);
    runJob("R7 quarter pattern", 2'b11, 3'd6, 1, 0, 1'b0);
    runJob("R8 quarter zero", 2'b11, 3'd0, 0, 0, 1'b1);
    runJob("R8 half small", 2'b10, 3'd0, 0, 2, 1'b0);

    check("R9 queue drained", expQ.size() == 0, expQ.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule